// File: doc/BRIEF.md
# Truncated Switch-Tail Sequence Counter

This block is an N-stage twisted-ring shift counter. A two-bit mode input sets how long its cycle is. On each clock edge the stages move one place toward the leftmost stage, and a new bit enters at the rightmost stage. Which bit enters depends on the mode. In full mode the counter walks all 2N twisted-ring patterns. In odd mode it drops the all-zeros pattern, which gives 2N-1 states. In even mode it also drops the all-ones pattern, which gives 2N-2 states. A control block can use this to get an odd or even divide ratio from the same register, changing the ratio only in the logic that feeds the serial input.

A synchronous active-low clear loads the start pattern, in which only the rightmost stage is 1. Clear takes priority over counting. Any pattern that is not a member of the cycle currently selected goes back to the start pattern on the next edge, so a change of mode can never lock the counter up. A terminal flag marks the last member of every cycle. An output enable forces the visible stage bits to zero while the counter keeps running underneath.

Top module: `twist_cycle_ctr`

## Requirements
- R1: When `clr_n` is low at a rising clock edge, the state after that edge is 00..01 (only `stage_q[0]` set), whatever the mode and whatever the state before.
- R2: With `mode`=00 the state follows the 2N cycle. The new bit is the inverse of `stage_q[N-1]`. For N=4 the order is 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000, and then 0001 again.
- R3: With `mode`=01 the cycle has 2N-1 states. The pattern 10..0 is followed by 00..01, and 00..00 never follows an edge.
- R4: With `mode`=10 the cycle has 2N-2 states. The pattern 01..1 is followed by 11..10, and 10..0 is followed by 00..01. Neither 11..11 nor 00..00 follows an edge.
- R5: `mode`=11 gives exactly the same sequence as `mode`=00.
- R6: A state that is not a member of the selected cycle goes to 00..01 on the next edge. Examples are a non-twisted pattern, 00..00 in odd or even mode, and 11..11 in even mode.
- R7: `last_state` is high exactly while the state is 10..0, in every mode and independent of `out_en`. The next edge after it takes the counter back to 00..01, unless the mode is 00 or 11.
- R8: While `out_en` is low, `stage_q` reads all zeros and the state still advances. While `out_en` is high, `stage_q` shows the state.
- R9: `stage_q[N-1]` is the leftmost stage. Each edge shifts the bits toward the higher index, and the new bit enters at `stage_q[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low; loads 00..01 |
| mode | input | 2 | Cycle select: 00 full, 01 odd, 10 even, 11 full |
| out_en | input | 1 | High shows the state on `stage_q`; low shows zeros |
| stage_q | output | N | Stage bits, leftmost stage at the highest index |
| last_state | output | 1 | High while the state is 10..0 |

## Verification
The recovery path is the hard one to reach. Starting from a clear, every state that can be reached belongs to a legal cycle. A state outside the selected cycle only appears when the mode changes while the counter sits on a pattern the new mode skips. The stimulus runs full mode up to 0000 and then switches to odd mode, and runs full mode up to 1111 and then switches to even mode. At 1111 the even feedback alone would produce 1110, so only the recovery logic yields 0001. The random section changes mode at arbitrary points to reach further skipped states, and an independent reference model checks each of them.

// File: rtl/twc_pkg.sv
package twc_pkg;
  typedef enum logic [1:0] {
    CYC_FULL     = 2'b00,
    CYC_ODD      = 2'b01,
    CYC_EVEN     = 2'b10,
    CYC_FULL_ALT = 2'b11
  } cyc_mode_e;
endpackage

// File: rtl/twc_member_chk.sv
// Flags whether the present state belongs to the cycle the mode selects.
module twc_member_chk #(
  parameter int N = 4
) (
  input  logic [N-1:0] state,
  input  logic [1:0]   mode,
  output logic         in_cycle
);
  import twc_pkg::*;
  localparam int NPAT = 2 * N;
  localparam logic [N-1:0] ONES = '1;
  localparam int IDX_ALL1 = N - 1;
  localparam int IDX_ALL0 = NPAT - 1;

  logic [NPAT-1:0] hit;
  logic [NPAT-1:0] allowed;

  // Pattern k: k+1 ones at the low end for k<N, else ones shifted left.
  for (genvar k = 0; k < NPAT; k++) begin : g_pat
    localparam logic [N-1:0] PAT = (k < N) ? (ONES >> (N - 1 - k))
                                           : (ONES << (k - N + 1));
    assign hit[k] = (state == PAT);
  end

  always_comb begin
    allowed = '1;
    case (cyc_mode_e'(mode))
      CYC_ODD:  allowed[IDX_ALL0] = 1'b0;
      CYC_EVEN: begin
        allowed[IDX_ALL0] = 1'b0;
        allowed[IDX_ALL1] = 1'b0;
      end
      default: ;
    endcase
  end

  assign in_cycle = |(hit & allowed);
endmodule

// File: rtl/twc_feedback.sv
// Serial bit for the rightmost stage, built from the two leftmost stages.
module twc_feedback #(
  parameter int N = 4
) (
  input  logic [N-1:0] state,
  input  logic [1:0]   mode,
  output logic         serial_in
);
  import twc_pkg::*;
  logic sa, sb;
  assign sa = state[N-1];
  assign sb = state[N-2];

  always_comb begin
    case (cyc_mode_e'(mode))
      CYC_ODD:  serial_in = ~(sa & sb);          // 10..0 re-enters at 00..01
      CYC_EVEN: serial_in = (~sa & ~sb) | (sa & ~sb); // also 01..1 -> 11..10
      default:  serial_in = ~sa;                 // plain twisted ring
    endcase
  end
endmodule

// File: rtl/twc_stage_reg.sv
// State register: clear first, then recovery, then shift.
module twc_stage_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         in_cycle,
  input  logic         serial_in,
  output logic [N-1:0] state
);
  localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!clr_n)        state <= START;
    else if (!in_cycle) state <= START;
    else               state <= {state[N-2:0], serial_in};
  end
endmodule

// File: rtl/twist_cycle_ctr.sv
module twist_cycle_ctr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         out_en,
  output logic [N-1:0] stage_q,
  output logic         last_state
);
  localparam logic [N-1:0] LAST = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] cnt_q;
  logic         in_cycle;
  logic         serial_in;

  twc_member_chk #(.N(N)) u_member (
    .state(cnt_q), .mode(mode), .in_cycle(in_cycle)
  );

  twc_feedback #(.N(N)) u_fb (
    .state(cnt_q), .mode(mode), .serial_in(serial_in)
  );

  twc_stage_reg #(.N(N)) u_reg (
    .clk(clk), .clr_n(clr_n), .in_cycle(in_cycle),
    .serial_in(serial_in), .state(cnt_q)
  );

  assign stage_q    = out_en ? cnt_q : '0;
  assign last_state = (cnt_q == LAST);
endmodule

// File: rtl/twc_checker.sv
module twc_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         clr_n,
  input logic [1:0]   mode,
  input logic         out_en,
  input logic [N-1:0] stage_q,
  input logic         last_state,
  input logic [N-1:0] cnt_q
);
  localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] ALLONE = '1;

  // Clear is the reset, so this one cannot be disabled by it.
  assert_clear_start_R1: assert property (@(posedge clk)
    !clr_n |=> cnt_q == START);

  assert_full_step_R2: assert property (@(posedge clk) disable iff (!clr_n)
    ((mode == 2'b00 || mode == 2'b11) &&
     $countones(cnt_q[N-1:1] ^ cnt_q[N-2:0]) <= 1)
    |=> cnt_q == {$past(cnt_q[N-2:0]), ~$past(cnt_q[N-1])});

  assert_odd_no_zero_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b01) |=> cnt_q != '0);

  assert_even_no_ones_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b10) |=> (cnt_q != ALLONE && cnt_q != '0));

  assert_bad_shape_recover_R6: assert property (@(posedge clk) disable iff (!clr_n)
    ($countones(cnt_q[N-1:1] ^ cnt_q[N-2:0]) > 1) |=> cnt_q == START);

  assert_last_wraps_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (last_state && mode != 2'b00 && mode != 2'b11) |=> cnt_q == START);

  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!clr_n)
    stage_q == (out_en ? cnt_q : '0));
endmodule

bind twist_cycle_ctr twc_checker #(.N(N)) u_chk (
  .clk(clk), .clr_n(clr_n), .mode(mode), .out_en(out_en),
  .stage_q(stage_q), .last_state(last_state), .cnt_q(cnt_q)
);

// File: tb/tb_twist_cycle_ctr.sv
module tb_twist_cycle_ctr;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;
  localparam logic [N-1:0] START = 4'b0001;
  localparam logic [N-1:0] LAST  = 4'b1000;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         out_en = 1'b1;
  logic [N-1:0] stage_q;
  logic         last_state;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] exp_st = START;

  twist_cycle_ctr #(.N(N)) dut (
    .clk(clk), .clr_n(clr_n), .mode(mode), .out_en(out_en),
    .stage_q(stage_q), .last_state(last_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model written from the requirements.
  function automatic logic [N-1:0] ref_next(logic [N-1:0] s, logic c, logic [1:0] m);
    int trans;
    logic member;
    logic [N-1:0] plain;
    if (!c) return START;
    trans = 0;
    for (int i = 0; i < N-1; i++) if (s[i] != s[i+1]) trans++;
    member = (trans <= 1);
    if ((m == 2'b01 || m == 2'b10) && s == '0) member = 1'b0;
    if (m == 2'b10 && s == '1) member = 1'b0;
    if (!member) return START;
    plain = {s[N-2:0], ~s[N-1]};
    if (m == 2'b01 && s == LAST) return START;
    if (m == 2'b10 && s == LAST) return START;
    if (m == 2'b10 && s == {1'b0, {(N-1){1'b1}}}) return {{(N-1){1'b1}}, 1'b0};
    return plain;
  endfunction

  task automatic tick(input logic c, input logic [1:0] m, input logic o);
    clr_n = c; mode = m; out_en = o;
    @(negedge clk);
    exp_st = ref_next(exp_st, c, m);
  endtask

  task automatic chk(input string tag, input logic [N-1:0] want);
    logic [N-1:0] vis;
    vis = out_en ? want : '0;
    checks++;
    if (stage_q !== vis || last_state !== (want == LAST)) begin
      fails++;
      $display("FAIL %s: stage_q=%b last=%b expected stage_q=%b last=%b",
               tag, stage_q, last_state, vis, (want == LAST));
    end
  endtask

  task automatic run_list(input string tag, input logic [1:0] m,
                          input logic [N-1:0] seq [], input int len);
    for (int i = 0; i < len; i++) begin
      tick(1'b1, m, 1'b1);
      chk(tag, seq[i]);
      if (exp_st !== seq[i]) begin
        fails++;
        $display("FAIL %s: model=%b expected=%b", tag, exp_st, seq[i]);
      end
    end
  endtask

  initial begin
    logic [N-1:0] full_seq [];
    logic [N-1:0] odd_seq [];
    logic [N-1:0] even_seq [];
    int unsigned seed;
    logic [1:0] rm;
    full_seq = '{4'b0011, 4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0000, 4'b0001};
    odd_seq  = '{4'b0011, 4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000, 4'b0001};
    even_seq = '{4'b0011, 4'b0111, 4'b1110, 4'b1100, 4'b1000, 4'b0001};
    seed = 32'd20240613;
    void'($urandom(seed));

    @(negedge clk);
    tick(1'b0, 2'b00, 1'b1); chk("R1 reset state", START);

    run_list("R2 R9 full cycle", 2'b00, full_seq, 8);
    tick(1'b0, 2'b00, 1'b1); chk("R1 clear", START);
    run_list("R3 odd cycle", 2'b01, odd_seq, 7);
    run_list("R3 odd second lap", 2'b01, odd_seq, 7);
    run_list("R4 even cycle", 2'b10, even_seq, 6);
    run_list("R5 mode 11", 2'b11, full_seq, 8);

    // Clear beats counting mid-cycle.
    tick(1'b1, 2'b01, 1'b1); tick(1'b1, 2'b01, 1'b1);
    tick(1'b0, 2'b01, 1'b1); chk("R1 clear priority", START);

    // Full to 0000, then odd: skipped state recovers.
    for (int i = 0; i < 7; i++) tick(1'b1, 2'b00, 1'b1);
    chk("R6 at zeros", 4'b0000);
    tick(1'b1, 2'b01, 1'b1); chk("R6 odd from zeros", START);

    // Full to 1111, then even: must go to 0001, not 1110.
    for (int i = 0; i < 3; i++) tick(1'b1, 2'b00, 1'b1);
    chk("R6 at ones", 4'b1111);
    tick(1'b1, 2'b10, 1'b1); chk("R6 even from ones", START);

    // Output enable low, state keeps moving.
    tick(1'b1, 2'b00, 1'b0); chk("R8 gated", 4'b0011);
    tick(1'b1, 2'b00, 1'b0); chk("R8 gated", 4'b0111);
    out_en = 1'b1; #1; chk("R8 advanced under gate", 4'b0111);
    for (int i = 0; i < 4; i++) tick(1'b1, 2'b00, 1'b0);
    chk("R7 flag with gate low", LAST);
    tick(1'b1, 2'b10, 1'b1); chk("R7 even wraps after last", START);

    // Constrained random: held modes with occasional switches and clears.
    rm = 2'b00;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 12 == 0) rm = 2'($urandom % 4);
      tick(($urandom % 50) != 0, rm, ($urandom % 4) != 0);
      case (rm)
        2'b00: chk("R2 random full", exp_st);
        2'b01: chk("R3 random odd", exp_st);
        2'b10: chk("R4 random even", exp_st);
        default: chk("R5 random mode 11", exp_st);
      endcase
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule